// File: doc/BRIEF.md
# I2C Line Conditioner and Bus Event Detector

This block sits between the raw two-wire serial bus pins and a slave-side byte controller. It samples the clock line and the data line with the system clock, passes each through a two-flop synchroniser and a hold-time filter, and presents clean filtered levels of both lines. From those filtered levels it derives four one-cycle event strobes: bus start, bus stop, clock rising and clock falling.

A filtered line changes only after its synchronised input has held a new value for `FILT_LEN` consecutive system clocks. This discards spikes narrower than the bus specification allows. At 50 MHz the default of four clocks covers 80 ns, which is above the 50 ns spike limit. Start and stop are judged only from the filtered lines. The clock line must be high in both the current and the previous filtered sample for a data edge to count as a start or a stop.

Two gates stop events from being reported. After reset is released, a counter blocks every event for `HOLDOFF_CYCLES` clocks; the default is 200 µs at 50 MHz. While the `busy_i` input is high, for example during an internal write cycle of the attached memory, events are also blocked. Under both gates the filtered levels keep following the bus.

Top module: `i2c_line_event_filter`

## Requirements
- R1: A stable change on a raw line appears on its filtered output (`scl_o` or `sda_o`) exactly `FILT_LEN`+2 clock edges after the change is first sampled. The matching event strobe follows one edge later.
- R2: A raw pulse on either line that lasts fewer than `FILT_LEN` samples leaves the filtered level and all events unchanged. A pulse of `FILT_LEN` samples or more is passed through.
- R3: `start_o` pulses once when filtered SDA falls while filtered SCL is 1 in that sample and in the sample before.
- R4: `stop_o` pulses once when filtered SDA rises while filtered SCL is 1 in that sample and in the sample before.
- R5: `scl_rise_o` and `scl_fall_o` each pulse once per filtered SCL rising or falling transition. During normal bit transfers no start or stop is reported, and `sda_o` at each `scl_rise_o` holds the transmitted bit.
- R6: An SDA edge in the same filtered sample as an SCL edge, in either direction, gives no start and no stop. The SCL edge itself is still reported.
- R7: For the first `HOLDOFF_CYCLES` clocks after reset release, no event output goes high. `scl_o` and `sda_o` still follow the bus during this time.
- R8: While `busy_i` is 1, no event output goes high, and `sda_o` and `scl_o` still follow the bus.
- R9: During reset and right after it, `scl_o` and `sda_o` read 1 (idle bus) and all four event outputs read 0.
- R10: Every event output is high for exactly one clock per detected event and never for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_raw_i | input | 1 | Raw bus clock line |
| sda_raw_i | input | 1 | Raw bus data line |
| busy_i | input | 1 | High blocks all event reporting |
| scl_o | output | 1 | Filtered clock level |
| sda_o | output | 1 | Filtered data level |
| start_o | output | 1 | One-clock start strobe |
| stop_o | output | 1 | One-clock stop strobe |
| scl_rise_o | output | 1 | One-clock filtered clock rising strobe |
| scl_fall_o | output | 1 | One-clock filtered clock falling strobe |

## Verification
The bench sweeps the glitch width from one sample up to two past the filter length on both lines. A filter that is off by one at this boundary either lets a spike of `FILT_LEN`-1 samples through as a false start or stop, or swallows a real edge of exactly `FILT_LEN` samples. It drives SDA and SCL edges onto the same sample in both directions. A detector that looks only at the current SCL level would report a false start or stop there.

The bench measures the filtered-level and strobe latency to the exact edge. It runs bytes of bus traffic and checks the bit captured at each clock rise. It applies start, stop and clock activity during the power-up hold-off and under `busy_i`, and confirms that the filtered levels still move while nothing is reported. A design that gated the levels instead of the strobes would fail those level checks.

// File: rtl/lcf_pkg.sv
package lcf_pkg;

    // Line index used for the vector of conditioned lines
    localparam int unsigned LINE_SCL = 0;
    localparam int unsigned LINE_SDA = 1;
    localparam int unsigned N_LINES  = 2;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } lcf_evt_t;

    localparam lcf_evt_t EVT_NONE = '{start: 1'b0, stop: 1'b0, rise: 1'b0, fall: 1'b0};

endpackage

// File: rtl/lcf_sync.sv
module lcf_sync #(
    parameter int unsigned W       = 2,
    parameter bit          RST_LVL = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = d_i;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{stage1: {W{RST_LVL}}, stage2: {W{RST_LVL}}};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.stage2;

endmodule

// File: rtl/lcf_glitch_filter.sv
module lcf_glitch_filter #(
    parameter int unsigned FILT_LEN = 4,
    parameter bit          RST_LVL  = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic in_i,
    output logic lvl_o
);

    localparam int unsigned CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LIM = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (in_i != st_q.lvl) begin
            if (st_q.cnt == LIM) begin
                st_d.lvl = in_i;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{lvl: RST_LVL, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;

    // The filtered level only ever moves to the value the input held
    AST_FILT_TOWARD_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.lvl != $past(st_q.lvl)) |-> (st_q.lvl == $past(in_i))); // R2

    // After a change, the level stays put for at least one more clock
    AST_FILT_NO_CHATTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.lvl != $past(st_q.lvl)) |=> (st_q.lvl == $past(st_q.lvl))); // R2

endmodule

// File: rtl/lcf_holdoff.sv
module lcf_holdoff #(
    parameter int unsigned HOLDOFF_CYCLES = 10000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic ready_o
);

    localparam int unsigned CW = $clog2(HOLDOFF_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLDOFF_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.ready) begin
            if (st_q.cnt == LAST) begin
                st_d.ready = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, ready: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = st_q.ready;

    // Once released, the lockout never re-engages without reset
    AST_HOLDOFF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ready |=> st_q.ready); // R7

endmodule

// File: rtl/i2c_line_event_filter.sv
module i2c_line_event_filter
    import lcf_pkg::*;
#(
    parameter int unsigned FILT_LEN       = 4,
    parameter int unsigned HOLDOFF_CYCLES = 10000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_raw_i,
    input  logic sda_raw_i,
    input  logic busy_i,
    output logic scl_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] synced;
    logic [N_LINES-1:0] filtered;
    logic               ready;

    assign raw_lines[LINE_SCL] = scl_raw_i;
    assign raw_lines[LINE_SDA] = sda_raw_i;

    lcf_sync #(
        .W       (N_LINES),
        .RST_LVL (1'b1)
    ) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_lines),
        .q_o    (synced)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        lcf_glitch_filter #(
            .FILT_LEN (FILT_LEN),
            .RST_LVL  (1'b1)
        ) filt_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .in_i   (synced[g]),
            .lvl_o  (filtered[g])
        );
    end

    lcf_holdoff #(
        .HOLDOFF_CYCLES (HOLDOFF_CYCLES)
    ) holdoff_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ready_o (ready)
    );

    typedef struct packed {
        logic     scl_prev;
        logic     sda_prev;
        lcf_evt_t evt;
    } det_st_t;

    det_st_t  st_d, st_q;
    lcf_evt_t found;
    logic     scl_f, sda_f;

    assign scl_f = filtered[LINE_SCL];
    assign sda_f = filtered[LINE_SDA];

    always_comb begin
        found       = EVT_NONE;
        found.start = scl_f & st_q.scl_prev & st_q.sda_prev & ~sda_f;
        found.stop  = scl_f & st_q.scl_prev & ~st_q.sda_prev & sda_f;
        found.rise  = scl_f & ~st_q.scl_prev;
        found.fall  = ~scl_f & st_q.scl_prev;

        st_d          = st_q;
        st_d.scl_prev = scl_f;
        st_d.sda_prev = sda_f;
        st_d.evt      = (ready && !busy_i) ? found : EVT_NONE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{scl_prev: 1'b1, sda_prev: 1'b1, evt: EVT_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_o      = scl_f;
    assign sda_o      = sda_f;
    assign start_o    = st_q.evt.start;
    assign stop_o     = st_q.evt.stop;
    assign scl_rise_o = st_q.evt.rise;
    assign scl_fall_o = st_q.evt.fall;

    AST_START_NEEDS_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> ($past(scl_o) && !$past(sda_o))); // R3

    AST_STOP_NEEDS_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_o |-> ($past(scl_o) && $past(sda_o))); // R4

    AST_NO_EVT_IN_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready |-> !(start_o || stop_o || scl_rise_o || scl_fall_o)); // R7

    AST_NO_EVT_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(busy_i) |-> !(start_o || stop_o || scl_rise_o || scl_fall_o)); // R8

    AST_EVT_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_o || stop_o || scl_rise_o || scl_fall_o)
        |=> !(start_o || stop_o || scl_rise_o || scl_fall_o)); // R10

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o})); // R6

endmodule

// File: tb/i2c_line_event_filter_tb_top.sv
module i2c_line_event_filter_tb_top;

    localparam int unsigned FILT = 4;
    localparam int unsigned HOLD = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_raw = 1'b1, sda_raw = 1'b1, busy = 1'b0;
    logic scl_f, sda_f, start_e, stop_e, rise_e, fall_e;

    int n_vec = 0, n_bad = 0;
    int c_start = 0, c_stop = 0, c_rise = 0, c_fall = 0, c_double = 0;
    logic [7:0] cap = 8'h00;
    logic prev_any = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    i2c_line_event_filter #(
        .FILT_LEN       (FILT),
        .HOLDOFF_CYCLES (HOLD)
    ) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .scl_raw_i  (scl_raw),
        .sda_raw_i  (sda_raw),
        .busy_i     (busy),
        .scl_o      (scl_f),
        .sda_o      (sda_f),
        .start_o    (start_e),
        .stop_o     (stop_e),
        .scl_rise_o (rise_e),
        .scl_fall_o (fall_e)
    );

    // Event monitor, sampled half a period after the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_e) c_start++;
            if (stop_e)  c_stop++;
            if (rise_e) begin
                c_rise++;
                cap = {cap[6:0], sda_f};
            end
            if (fall_e)  c_fall++;
            if (prev_any && (start_e || stop_e || rise_e || fall_e)) c_double++;
            prev_any = start_e || stop_e || rise_e || fall_e;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    int s0, p0, r0, f0;
    task automatic snap();
        s0 = c_start; p0 = c_stop; r0 = c_rise; f0 = c_fall;
    endtask

    task automatic chk_counts(input string req, input int es, input int ep, input int er, input int ef);
        chk({req, " start"}, c_start - s0, es);
        chk({req, " stop"},  c_stop  - p0, ep);
        chk({req, " rise"},  c_rise  - r0, er);
        chk({req, " fall"},  c_fall  - f0, ef);
    endtask

    task automatic send_byte(input logic [7:0] b);
        sda_raw = 1'b0; step(12);          // start
        scl_raw = 1'b0; step(10);
        for (int i = 7; i >= 0; i--) begin
            sda_raw = b[i]; step(10);
            scl_raw = 1'b1; step(10);
            scl_raw = 1'b0; step(10);
        end
        sda_raw = 1'b0; step(10);
        scl_raw = 1'b1; step(12);
        sda_raw = 1'b1; step(12);          // stop
    endtask

    initial begin
        step(3);
        // R9: reset state
        chk("R9 scl_o", int'(scl_f), 1);
        chk("R9 sda_o", int'(sda_f), 1);
        chk("R9 events", int'({start_e, stop_e, rise_e, fall_e}), 0);
        rst_n = 1'b1;
        step(1);
        chk("R9 scl_o after release", int'(scl_f), 1);

        // R7: bus activity during hold-off gives no events, levels still move
        snap();
        step(10);
        sda_raw = 1'b0; step(20);
        chk("R7 sda_o tracks in holdoff", int'(sda_f), 0);
        scl_raw = 1'b0; step(20);
        scl_raw = 1'b1; step(20);
        sda_raw = 1'b1; step(20);
        chk_counts("R7 holdoff", 0, 0, 0, 0);
        step(HOLD + 20);

        // R1: exact latency of filtered level and start strobe
        snap();
        sda_raw = 1'b0;
        step(FILT + 1);
        chk("R1 sda_o before latency", int'(sda_f), 1);
        step(1);
        chk("R1 sda_o at latency", int'(sda_f), 0);
        chk("R1 start not yet", int'(start_e), 0);
        step(1);
        chk("R1 R3 start strobe edge", int'(start_e), 1);
        step(1);
        chk("R10 start single cycle", int'(start_e), 0);
        sda_raw = 1'b1; step(20);
        chk_counts("R3 R4 start then stop", 1, 1, 0, 0);

        // R2: glitch width sweep on SDA with SCL high
        for (int w = 1; w <= int'(FILT) + 2; w++) begin
            snap();
            sda_raw = 1'b0; step(w);
            sda_raw = 1'b1; step(20);
            chk_counts($sformatf("R2 sda pulse w=%0d", w),
                       (w >= int'(FILT)) ? 1 : 0, (w >= int'(FILT)) ? 1 : 0, 0, 0);
        end
        // R2: glitch width sweep on SCL with SDA high
        for (int w = 1; w <= int'(FILT) + 2; w++) begin
            snap();
            scl_raw = 1'b0; step(w);
            scl_raw = 1'b1; step(20);
            chk_counts($sformatf("R2 scl pulse w=%0d", w),
                       0, 0, (w >= int'(FILT)) ? 1 : 0, (w >= int'(FILT)) ? 1 : 0);
        end

        // R6: coincident edges
        snap();
        scl_raw = 1'b0; sda_raw = 1'b0; step(20);
        chk_counts("R6 both fall", 0, 0, 0, 1);
        snap();
        scl_raw = 1'b1; sda_raw = 1'b1; step(20);
        chk_counts("R6 both rise", 0, 0, 1, 0);
        snap();
        scl_raw = 1'b0; step(20);
        scl_raw = 1'b1; sda_raw = 1'b0; step(20);
        chk_counts("R6 scl rise with sda fall", 0, 0, 1, 1);
        snap();
        scl_raw = 1'b0; sda_raw = 1'b1; step(20);
        chk_counts("R6 scl fall with sda rise", 0, 0, 0, 1);
        scl_raw = 1'b1; step(20);

        // R5: byte traffic sweep
        for (int b = 0; b < 24; b++) begin
            logic [7:0] v;
            v = 8'(b * 37 + 5);
            snap();
            send_byte(v);
            chk_counts($sformatf("R5 byte %0d", b), 1, 1, 9, 9);
            chk($sformatf("R5 captured bits byte %0d", b), int'(cap), int'({v[6:0], 1'b0}));
        end

        // R8: busy blocks events but levels follow
        busy = 1'b1;
        snap();
        sda_raw = 1'b0; step(20);
        chk("R8 sda_o tracks while busy", int'(sda_f), 0);
        scl_raw = 1'b0; step(20);
        chk("R8 scl_o tracks while busy", int'(scl_f), 0);
        scl_raw = 1'b1; step(20);
        sda_raw = 1'b1; step(20);
        chk_counts("R8 busy", 0, 0, 0, 0);
        busy = 1'b0; step(5);
        snap();
        sda_raw = 1'b0; step(20);
        sda_raw = 1'b1; step(20);
        chk_counts("R8 after busy", 1, 1, 0, 0);

        chk("R10 no back-to-back strobes", c_double, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule